// File: doc/BRIEF.md
# Rotate-and-Mask Datapath Unit

This unit performs the core arithmetic of rotate-with-mask integer instructions. A source operand is optionally sign-extended from its low half, rotated left by a shift amount, and then ANDed with a contiguous (or wrapping) bit mask described by a begin index and an end index. A mode input selects either a full-width rotation or a rotation confined to the low half-word.

Mask indices use big-endian bit numbering: index 0 names the most significant bit of the word and index XLEN-1 names the least significant bit. When the begin index is larger than the end index, the mask wraps around the word. For half-word instruction forms the caller adds HALF (32) to the 5-bit indices, because the unit does not do this itself.

A parameter selects whether the result leaves combinationally or through one register stage. In registered form, `out_valid` follows `in_valid` one cycle later. The result holds while `in_valid` is low.

Top module: `rotmask_unit`

## Requirements
- R1: With `word32`=0, the operand is rotated left by `amt` taken modulo XLEN (all 6 bits of `amt` are used); e.g. 0xdeadbeef12345678 rotated by 10 gives 0xb6fbbc48d159e37a, and rotated by 35 gives 0x91a2b3c6f56df778.
- R2: With `word32`=1, only the low 32 bits of the operand are rotated, by `amt[4:0]`. `amt[5]` and the upper source bits have no effect, and result bits 63..32 are zero. For example, 0xdeadbeef rotated by 10 gives 0xb6fbbf7a.
- R3: Mask index i selects result bit 63-i. When `mask_begin` <= `mask_end`, the mask bits from `mask_begin` through `mask_end` inclusive are set and all others are clear. For example, begin 37 and end 63 gives 0x7ffffff, and begin 0 and end 10 gives 0xffe0000000000000.
- R4: When `mask_begin` > `mask_end`, the mask sets index `mask_begin`..63 and index 0..`mask_end` and clears the indices strictly between them. For example, begin 47 and end 37 gives 0xfffffffffc01ffff.
- R5: When `mask_begin` equals `mask_end`, exactly one mask bit is set.
- R6: When `mask_begin` equals `mask_end`+1 (modulo 64), the mask is all ones.
- R7: The result is the rotated value ANDed with the mask. With `amt`=0 and an all-ones source, the result equals the mask.
- R8: With `sext`=1, bit 31 of `src` is copied into bits 63..32 before rotation; e.g. 0x80000000 becomes 0xffffffff80000000, and 0xffffffff73123456 becomes 0x73123456. In half-word mode `sext` has no effect.
- R9: With REGISTERED=1, the result and `out_valid` reset to zero. A new result appears on the clock edge that samples `in_valid`=1, and `out_valid` equals `in_valid` delayed by one cycle. While `in_valid` is 0 the result holds its value.
- R10: With REGISTERED=0, `result` and `out_valid` follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (output stage and assertions) |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands valid this cycle |
| src | input | XLEN | Source operand |
| amt | input | SHW | Left-rotate amount |
| mask_begin | input | SHW | First mask index (MSB = 0) |
| mask_end | input | SHW | Last mask index (MSB = 0) |
| word32 | input | 1 | 1: rotate within low half-word |
| sext | input | 1 | 1: sign-extend low half of src first |
| out_valid | output | 1 | Result valid |
| result | output | XLEN | Rotated and masked value |

## Verification
The assertions assume that every input is a known value on each clock edge after reset, because the bit-count and mask properties compare inputs directly. They also assume that the caller applies the +32 index offset for half-word forms. The bench drives every input, including the mask indices, at the falling edge from reset onward, so no X ever reaches an edge. Its random stimulus draws full-range 6-bit indices and steers some draws into the equal and adjacent-index cases, so both mask branches and the wrap boundary are exercised within legal encodings.

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter int XLEN       = 64,
  parameter bit REGISTERED = 1'b1,
  localparam int HALF      = XLEN / 2,
  localparam int SHW       = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [XLEN-1:0] src,
  input  logic [SHW-1:0]  amt,
  input  logic [SHW-1:0]  mask_begin,
  input  logic [SHW-1:0]  mask_end,
  input  logic            word32,
  input  logic            sext,
  output logic            out_valid,
  output logic [XLEN-1:0] result
);

  logic [XLEN-1:0]   operand;
  logic [2*XLEN-1:0] dbl_full;
  logic [XLEN-1:0]   dbl_half;
  logic [XLEN-1:0]   rot_full;
  logic [HALF-1:0]   rot_half;
  logic [XLEN-1:0]   rot_val;
  logic [XLEN-1:0]   mask;
  logic [XLEN-1:0]   comb_res;

  assign operand  = sext ? {{HALF{src[HALF-1]}}, src[HALF-1:0]} : src;
  assign dbl_full = {operand, operand} << amt;
  assign rot_full = dbl_full[2*XLEN-1:XLEN];
  assign dbl_half = {src[HALF-1:0], src[HALF-1:0]} << amt[SHW-2:0];
  assign rot_half = dbl_half[XLEN-1:HALF];
  assign rot_val  = word32 ? {{HALF{1'b0}}, rot_half} : rot_full;

  always_comb begin
    for (int k = 0; k < XLEN; k++) begin
      if (mask_begin <= mask_end)
        mask[k] = ((XLEN - 1 - k) >= int'(mask_begin)) && ((XLEN - 1 - k) <= int'(mask_end));
      else
        mask[k] = ((XLEN - 1 - k) >= int'(mask_begin)) || ((XLEN - 1 - k) <= int'(mask_end));
    end
  end

  assign comb_res = rot_val & mask;

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid <= 1'b0;
          result    <= '0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) result <= comb_res;
        end
      end

      p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
      p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && !out_valid));
    end else begin : g_comb
      assign out_valid = in_valid;
      assign result    = comb_res;

      p_comb_inside_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (result & ~mask) == '0);
    end
  endgenerate

  p_full_rot_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rot_full) == $countones(operand));
  p_half_rot_bits_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rot_half) == $countones(src[HALF-1:0]));
  p_mask_ends_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_begin <= mask_end) |-> (mask[XLEN-1-int'(mask_begin)] && mask[XLEN-1-int'(mask_end)]));
  p_wrap_ends_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_begin > mask_end) |-> (mask[0] && mask[XLEN-1]));
  p_single_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_begin == mask_end) |-> ($countones(mask) == 1));
  p_adjacent_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_begin == SHW'(mask_end + 1'b1)) |-> (&mask));

endmodule

// File: tb/test_rotmask_unit.sv
`timescale 1ns/1ps
module test_rotmask_unit;
  localparam int XLEN = 64;
  localparam int SHW  = 6;
  localparam int NV   = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [XLEN-1:0] src = '0;
  logic [SHW-1:0] amt = '0, mb = '0, me = '0;
  logic w32 = 1'b0, sx = 1'b0;
  logic vr, vc;
  logic [XLEN-1:0] res_r, res_c;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  rotmask_unit #(.XLEN(XLEN), .REGISTERED(1'b1)) i_rotmask_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .amt(amt),
    .mask_begin(mb), .mask_end(me), .word32(w32), .sext(sx),
    .out_valid(vr), .result(res_r));

  rotmask_unit #(.XLEN(XLEN), .REGISTERED(1'b0)) i_rotmask_unit_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .amt(amt),
    .mask_begin(mb), .mask_end(me), .word32(w32), .sext(sx),
    .out_valid(vc), .result(res_c));

  // layout: src[147:84] amt[83:78] begin[77:72] end[71:66] w32[65] sext[64] expected[63:0]
  localparam logic [147:0] VEC [NV] = '{
    {64'hdeadbeef12345678, 6'd10, 6'd0,  6'd63, 1'b0, 1'b0, 64'hb6fbbc48d159e37a},
    {64'hdeadbeef12345678, 6'd35, 6'd0,  6'd63, 1'b0, 1'b0, 64'h91a2b3c6f56df778},
    {64'h00000000deadbeef, 6'd10, 6'd32, 6'd63, 1'b1, 1'b0, 64'h00000000b6fbbf7a},
    {64'hffffffffdeadbeef, 6'd42, 6'd32, 6'd63, 1'b1, 1'b0, 64'h00000000b6fbbf7a},
    {64'hffffffffffffffff, 6'd0,  6'd37, 6'd63, 1'b0, 1'b0, 64'h0000000007ffffff},
    {64'hffffffffffffffff, 6'd0,  6'd0,  6'd10, 1'b0, 1'b0, 64'hffe0000000000000},
    {64'hffffffffffffffff, 6'd0,  6'd37, 6'd47, 1'b1, 1'b0, 64'h0000000007ff0000},
    {64'hffffffffffffffff, 6'd0,  6'd47, 6'd37, 1'b0, 1'b0, 64'hfffffffffc01ffff},
    {64'hffffffffffffffff, 6'd0,  6'd62, 6'd34, 1'b0, 1'b0, 64'hffffffffe0000003},
    {64'hffffffffffffffff, 6'd0,  6'd5,  6'd5,  1'b0, 1'b0, 64'h0400000000000000},
    {64'hffffffffffffffff, 6'd0,  6'd20, 6'd19, 1'b0, 1'b0, 64'hffffffffffffffff},
    {64'h0123456789abcdef, 6'd0,  6'd8,  6'd15, 1'b0, 1'b0, 64'h0023000000000000},
    {64'haaaaaaaa80000000, 6'd0,  6'd0,  6'd63, 1'b0, 1'b1, 64'hffffffff80000000},
    {64'hffffffff73123456, 6'd0,  6'd0,  6'd63, 1'b0, 1'b1, 64'h0000000073123456},
    {64'h00000000deadbeef, 6'd10, 6'd32, 6'd63, 1'b1, 1'b1, 64'h00000000b6fbbf7a}
  };
  localparam string TAG [NV] = '{"R1", "R1", "R2", "R2", "R3 R7", "R3", "R3", "R4",
                                 "R4", "R5", "R6", "R7", "R8", "R8", "R8"};

  function automatic logic [XLEN-1:0] model(logic [XLEN-1:0] s, int a, int b, int e,
                                             logic h, logic x);
    logic [XLEN-1:0] op, rot, msk;
    int n;
    op = s;
    if (x) for (int i = 32; i < XLEN; i++) op[i] = s[31];
    n = h ? 32 : XLEN;
    rot = '0;
    for (int i = 0; i < n; i++) rot[i] = op[(i - (a % n) + n) % n];
    for (int p = 0; p < XLEN; p++)
      msk[XLEN-1-p] = (b <= e) ? (p >= b && p <= e) : (p >= b || p <= e);
    return rot & msk;
  endfunction

  task automatic chk(string tag, logic [XLEN-1:0] got, logic [XLEN-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic run(logic [XLEN-1:0] s, logic [SHW-1:0] a, logic [SHW-1:0] b,
                     logic [SHW-1:0] e, logic h, logic x, logic [XLEN-1:0] exp, string tag);
    @(negedge clk);
    src = s; amt = a; mb = b; me = e; w32 = h; sx = x; in_valid = 1'b1;
    #1;
    chk({tag, " R10 comb"}, res_c, exp);
    chk("R10 comb valid", {63'd0, vc}, 64'd1);
    @(negedge clk);
    chk({tag, " R9 reg"}, res_r, exp);
    chk("R9 reg valid", {63'd0, vr}, 64'd1);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog got=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [XLEN-1:0] held;
    repeat (3) @(negedge clk);
    chk("R9 reset result", res_r, '0);
    chk("R9 reset valid", {63'd0, vr}, 64'd0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++)
      run(VEC[v][147:84], VEC[v][83:78], VEC[v][77:72], VEC[v][71:66],
          VEC[v][65], VEC[v][64], VEC[v][63:0], TAG[v]);

    // R9: idle input leaves the registered result untouched
    held = res_r;
    @(negedge clk);
    in_valid = 1'b0; src = 64'h5555aaaa5555aaaa; amt = 6'd7;
    @(negedge clk);
    chk("R9 hold result", res_r, held);
    chk("R9 idle valid", {63'd0, vr}, 64'd0);

    for (int i = 0; i < 400; i++) begin
      logic [XLEN-1:0] s;
      logic [SHW-1:0] a, b, e;
      logic h, x;
      s = {$urandom, $urandom};
      a = SHW'($urandom); b = SHW'($urandom); e = SHW'($urandom);
      h = 1'($urandom); x = 1'($urandom);
      if (i % 5 == 1) e = b;            // R5 corner
      if (i % 5 == 2) b = e + 1'b1;     // R6 corner
      run(s, a, b, e, h, x, model(s, int'(a), int'(b), int'(e), h, x), "R7 random");
    end

    // R9: asynchronous reset clears a live result
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R9 async reset result", res_r, '0);
    chk("R9 async reset valid", {63'd0, vr}, 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule